// File: doc/BRIEF.md
# Snoop-Initiated Writeback Response Sequencer

This block is the response-side controller of a bus agent on a pipelined, split-phase system bus. It logs each request as it is issued, with a single bit saying whether it is a write. It then waits for that request's snoop result, which arrives several clocks later. When the oldest request is fully known, the block decides whether a target-ready strobe is needed and raises it at the right time. It then drives a 3-bit response code for one cycle.

A plain read needs no target-ready strobe and gets a normal-data response. A write always needs the strobe. A read whose snoop reports a hit to a dirty line becomes an implicit writeback. In that case the block raises a snoop-initiated target-ready, but only once the previous response has finished. When the handshake completes, it drives the implicit-writeback code together with a data-drive enable exactly one clock later. For the requester the transfer then acts like a read, and for the addressed agent it acts like a write.

Top module: `snoop_wb_resp_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `tgt_rdy` and `resp_valid` are 0 and `wb_data_drive` is 0. `resp_code` is idle. Every tracked request is discarded, so nothing issued before reset is ever answered.
- R2: Response codes on `resp_code` are: idle = 3'b111, normal-data = 3'b100, implicit-writeback = 3'b101, no-data = 3'b110. `resp_code` is idle whenever `resp_valid` is 0.
- R3: A read whose snoop result reports no dirty hit never raises `tgt_rdy`. Its normal-data response appears in the second cycle after the cycle in which the snoop result is presented. `data_busy` and `prev_resp_done` do not affect it.
- R4: A read whose snoop reports a dirty hit raises `tgt_rdy`. It is answered with the implicit-writeback code.
- R5: The snoop-initiated `tgt_rdy` is first raised in the cycle after `prev_resp_done` is sampled high, and never earlier. The earliest it can appear is the second cycle after the snoop result.
- R6: A write raises `tgt_rdy` in the second cycle after its snoop result is presented, whatever the values of `prev_resp_done` and the snoop hit flag. It is answered with the no-data code.
- R7: A handshake is a cycle in which `tgt_rdy` is 1 and `data_busy` is 0. While `tgt_rdy` is 1 and `data_busy` is 1, `tgt_rdy` stays 1 in the next cycle and no response is driven.
- R8: The response for a transaction that raised `tgt_rdy` is driven in the cycle right after the handshake cycle, never earlier or later.
- R9: `wb_data_drive` is 1 exactly in the cycles that carry an implicit-writeback response.
- R10: `resp_valid` is 1 for exactly one cycle per transaction. In the following cycle `resp_code` is idle, `resp_valid` is 0 and `tgt_rdy` is 0 (default `HOLD_TRDY = 0`).
- R11: Several requests may be outstanding. Snoop results attach to the oldest request that has none yet, and responses leave in request order.
- R12: A snoop result presented while no request is waiting for one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is issued this cycle |
| req_is_write | input | 1 | 1 = write request, 0 = read request |
| snoop_valid | input | 1 | A snoop result is presented this cycle |
| snoop_hit_dirty | input | 1 | The snoop hit a modified line |
| data_busy | input | 1 | Data bus is busy this cycle |
| prev_resp_done | input | 1 | The previous transaction's response has completed |
| tgt_rdy | output | 1 | Target-ready strobe |
| resp_code | output | 3 | Response code, idle = 3'b111 |
| resp_valid | output | 1 | A response code is being driven this cycle |
| wb_data_drive | output | 1 | Drive writeback data onto the data bus this cycle |

## Verification
The bench measures the response cycle against a timing worked out from the snoop cycle, the busy window and the cycle in which the previous response completes. A design that answered an implicit writeback one clock early or late, or that ignored a busy data bus during the handshake, fails there. It checks that a dirty-hit read holds off its strobe while the previous response is still open. It also checks that a write ignores both that gate and the hit flag. A design that mixed up these paths would show the strobe at the wrong time or return the wrong code. A stray snoop, given while nothing was pending, followed by an unsnooped read, would produce a premature response if the stray result were wrongly attached. A reset in mid-handshake followed by silence would expose a design that kept stale requests.

// File: rtl/swr_pkg.sv
package swr_pkg;

    // Response codes: the bus is inactive-high, so all-ones means idle.
    typedef enum logic [2:0] {
        RSP_NORMAL = 3'b100,
        RSP_IWB    = 3'b101,
        RSP_NODATA = 3'b110,
        RSP_IDLE   = 3'b111
    } rsp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRDY,
        ST_RESP
    } seq_st_e;

    // One outstanding transaction.
    typedef struct packed {
        logic is_wr;
        logic snooped;
        logic hitm;
    } txn_ent_t;

endpackage

// File: rtl/swr_tracker.sv
// Holds issued requests in order until their snoop results are known.
// DEPTH must be a power of two, at least 2.
module swr_tracker
    import swr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_is_wr,
    input  logic snoop_valid,
    input  logic snoop_hitm,
    input  logic pop,
    output logic head_ready,
    output logic head_is_wr,
    output logic head_hitm
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

    typedef struct packed {
        txn_ent_t [DEPTH-1:0] ent;
        logic [PW-1:0]        wr_ptr;
        logic [PW-1:0]        rd_ptr;
        logic [PW-1:0]        sn_ptr;
        logic [PW:0]          used;
        logic [PW:0]          snooped;
    } trk_t;

    trk_t q, d;
    logic acc_req, acc_snp, do_pop;

    always_comb begin
        d       = q;
        acc_req = req_valid && (q.used < FULL_CNT);
        acc_snp = snoop_valid && (q.snooped < q.used);
        do_pop  = pop && head_ready;

        if (acc_req) begin
            d.ent[q.wr_ptr] = '{is_wr: req_is_wr, snooped: 1'b0, hitm: 1'b0};
            d.wr_ptr        = q.wr_ptr + 1'b1;
        end
        if (acc_snp) begin
            d.ent[q.sn_ptr].snooped = 1'b1;
            d.ent[q.sn_ptr].hitm    = snoop_hitm;
            d.sn_ptr                = q.sn_ptr + 1'b1;
        end
        if (do_pop) begin
            d.ent[q.rd_ptr].snooped = 1'b0;
            d.rd_ptr                = q.rd_ptr + 1'b1;
        end
        d.used    = q.used + (PW+1)'(acc_req) - (PW+1)'(do_pop);
        d.snooped = q.snooped + (PW+1)'(acc_snp) - (PW+1)'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_ready = (q.snooped != '0);
    assign head_is_wr = q.ent[q.rd_ptr].is_wr;
    assign head_hitm  = q.ent[q.rd_ptr].hitm;

endmodule

// File: rtl/swr_resp_fsm.sv
// Target-ready handshake and response-phase sequencing for the oldest
// fully-snooped transaction.
module swr_resp_fsm
    import swr_pkg::*;
#(
    parameter int HOLD_TRDY = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       head_ready,
    input  logic       head_is_wr,
    input  logic       head_hitm,
    input  logic       data_busy,
    input  logic       prev_done,
    output logic       pop,
    output logic       tgt_rdy,
    output logic [2:0] resp_code,
    output logic       resp_valid,
    output logic       data_drive
);

    typedef struct packed {
        seq_st_e   st;
        logic      trdy;
        logic      wb;
        rsp_code_e rs;
        logic      rsv;
        logic      drv;
    } fsm_t;

    fsm_t q, d;
    logic keep_trdy;

    // Choose whether the strobe drops after the handshake or stays up
    // through the response cycle.
    generate
        if (HOLD_TRDY != 0) begin : g_hold
            assign keep_trdy = 1'b1;
        end else begin : g_drop
            assign keep_trdy = 1'b0;
        end
    endgenerate

    always_comb begin
        d     = q;
        pop   = 1'b0;
        d.rs  = RSP_IDLE;
        d.rsv = 1'b0;
        d.drv = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (head_ready) begin
                    if (head_is_wr) begin
                        d.st   = ST_TRDY;
                        d.trdy = 1'b1;
                        d.wb   = 1'b0;
                    end else if (head_hitm) begin
                        if (prev_done) begin
                            d.st   = ST_TRDY;
                            d.trdy = 1'b1;
                            d.wb   = 1'b1;
                        end
                    end else begin
                        pop   = 1'b1;
                        d.st  = ST_RESP;
                        d.rs  = RSP_NORMAL;
                        d.rsv = 1'b1;
                    end
                end
            end
            ST_TRDY: begin
                if (!data_busy) begin
                    pop    = 1'b1;
                    d.st   = ST_RESP;
                    d.rs   = q.wb ? RSP_IWB : RSP_NODATA;
                    d.rsv  = 1'b1;
                    d.drv  = q.wb;
                    d.trdy = keep_trdy;
                end
            end
            ST_RESP: begin
                d.st   = ST_IDLE;
                d.trdy = 1'b0;
                d.wb   = 1'b0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.rs <= RSP_IDLE;
        end else begin
            q <= d;
        end
    end

    assign tgt_rdy    = q.trdy;
    assign resp_code  = q.rs;
    assign resp_valid = q.rsv;
    assign data_drive = q.drv;

endmodule

// File: rtl/snoop_wb_resp_seq.sv
module snoop_wb_resp_seq
    import swr_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int HOLD_TRDY = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_is_write,
    input  logic       snoop_valid,
    input  logic       snoop_hit_dirty,
    input  logic       data_busy,
    input  logic       prev_resp_done,
    output logic       tgt_rdy,
    output logic [2:0] resp_code,
    output logic       resp_valid,
    output logic       wb_data_drive
);

    logic head_ready, head_is_wr, head_hitm, pop;

    swr_tracker #(.DEPTH(DEPTH)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_is_wr  (req_is_write),
        .snoop_valid(snoop_valid),
        .snoop_hitm (snoop_hit_dirty),
        .pop        (pop),
        .head_ready (head_ready),
        .head_is_wr (head_is_wr),
        .head_hitm  (head_hitm)
    );

    swr_resp_fsm #(.HOLD_TRDY(HOLD_TRDY)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_ready(head_ready),
        .head_is_wr(head_is_wr),
        .head_hitm (head_hitm),
        .data_busy (data_busy),
        .prev_done (prev_resp_done),
        .pop       (pop),
        .tgt_rdy   (tgt_rdy),
        .resp_code (resp_code),
        .resp_valid(resp_valid),
        .data_drive(wb_data_drive)
    );

endmodule

// File: rtl/swr_checker.sv
module swr_checker
    import swr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tgt_rdy,
    input logic       data_busy,
    input logic [2:0] resp_code,
    input logic       resp_valid,
    input logic       wb_data_drive
);

    // R1: outputs quiet in the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tgt_rdy && !resp_valid && !wb_data_drive && resp_code == RSP_IDLE));

    // R2: idle code whenever no response is driven
    a_r2_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> resp_code == RSP_IDLE);

    // R4: implicit writeback only follows a handshake
    a_r4_iwb_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == RSP_IWB) |-> ($past(tgt_rdy) && !$past(data_busy)));

    // R7: strobe held while the data bus is busy
    a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rdy && data_busy && !resp_valid) |=> (tgt_rdy && !resp_valid));

    // R8: response exactly one clock after the handshake
    a_r8_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rdy && !data_busy && !resp_valid) |=> resp_valid);

    // R9: data enable only alongside an implicit-writeback response
    a_r9_drive_iwb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_data_drive |-> (resp_valid && resp_code == RSP_IWB));

    // R10: response is a one-cycle pulse
    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && resp_code == RSP_IDLE));

endmodule

bind snoop_wb_resp_seq swr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tgt_rdy      (tgt_rdy),
    .data_busy    (data_busy),
    .resp_code    (resp_code),
    .resp_valid   (resp_valid),
    .wb_data_drive(wb_data_drive)
);

// File: tb/snoop_wb_resp_seq_bench.sv
`timescale 1ns/1ps
module snoop_wb_resp_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_is_write = 1'b0;
    logic       snoop_valid = 1'b0, snoop_hit_dirty = 1'b0;
    logic       data_busy = 1'b0, prev_resp_done = 1'b0;
    logic       tgt_rdy, resp_valid, wb_data_drive;
    logic [2:0] resp_code;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    snoop_wb_resp_seq u_snoop_wb_resp_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_is_write(req_is_write),
        .snoop_valid(snoop_valid), .snoop_hit_dirty(snoop_hit_dirty),
        .data_busy(data_busy), .prev_resp_done(prev_resp_done),
        .tgt_rdy(tgt_rdy), .resp_code(resp_code),
        .resp_valid(resp_valid), .wb_data_drive(wb_data_drive)
    );

    localparam logic [2:0] C_IDLE = 3'b111, C_NORM = 3'b100,
                           C_IWB  = 3'b101, C_NOD  = 3'b110;

    typedef struct packed {
        logic       wr;
        logic       hit;
        logic [3:0] db;   // busy for cycles [0, db)
        logic [3:0] pd;   // previous response done from cycle pd on
        logic [2:0] code;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'd0, 4'd0, C_NORM},   // R3 plain read
        '{1'b0, 1'b1, 4'd0, 4'd0, C_IWB },   // R4 dirty-hit read
        '{1'b0, 1'b1, 4'd5, 4'd0, C_IWB },   // R7 busy during handshake
        '{1'b0, 1'b1, 4'd0, 4'd4, C_IWB },   // R5 previous response late
        '{1'b1, 1'b0, 4'd0, 4'd6, C_NOD },   // R6 write ignores prev gate
        '{1'b1, 1'b0, 4'd4, 4'd0, C_NOD },   // R7 write with busy
        '{1'b1, 1'b1, 4'd0, 4'd0, C_NOD },   // R6 write ignores hit flag
        '{1'b0, 1'b0, 4'd6, 4'd9, C_NORM}    // R3 read ignores busy/prev
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic wr);
        req_valid = 1'b1; req_is_write = wr;
        tick;
        req_valid = 1'b0;
        tick; tick;
    endtask

    task automatic run_vec(input vec_t v);
        int  trdy_c, hs_exp, resp_exp, hs_cyc, resp_cyc, nresp;
        bit  saw_trdy, pd_seen, prev_hold;
        trdy_c   = v.wr ? 2 : ((int'(v.pd) + 1 > 2) ? int'(v.pd) + 1 : 2);
        hs_exp   = (int'(v.db) > trdy_c) ? int'(v.db) : trdy_c;
        resp_exp = (v.wr || v.hit) ? hs_exp + 1 : 2;
        hs_cyc = -10; resp_cyc = -10; nresp = 0;
        saw_trdy = 0; pd_seen = 0; prev_hold = 0;
        prev_resp_done = 1'b0;
        issue(v.wr);
        for (int i = 0; i < 30; i++) begin
            snoop_valid     = (i == 0);
            snoop_hit_dirty = v.hit;
            data_busy       = (i < int'(v.db));
            prev_resp_done  = (i >= int'(v.pd));
            @(negedge clk);
            if (tgt_rdy && !saw_trdy && !v.wr && v.hit)
                chk(pd_seen, "R5 strobe before prev done", i, trdy_c);
            if (tgt_rdy && !saw_trdy && v.wr)
                chk(i == 2, "R6 write strobe cycle", i, 2);
            if (tgt_rdy) saw_trdy = 1;
            if (prev_hold)
                chk(tgt_rdy && !resp_valid, "R7 strobe held while busy", tgt_rdy, 1);
            prev_hold = tgt_rdy && data_busy;
            if (tgt_rdy && !data_busy && hs_cyc < 0) hs_cyc = i;
            if (wb_data_drive)
                chk(resp_valid && resp_code == C_IWB, "R9 drive without iwb", resp_code, C_IWB);
            if (resp_valid) begin
                nresp++;
                resp_cyc = i;
                chk(resp_code == v.code, "R2 response code", resp_code, v.code);
                chk(wb_data_drive == (v.code == C_IWB), "R9 drive with response",
                    wb_data_drive, v.code == C_IWB);
                chk(i == resp_exp, (v.wr || v.hit) ? "R8 response cycle" : "R3 response cycle",
                    i, resp_exp);
                if (v.wr || v.hit)
                    chk(i == hs_cyc + 1, "R8 one clock after handshake", i, hs_cyc + 1);
            end
            if (i == resp_cyc + 1)
                chk(!resp_valid && resp_code == C_IDLE && !tgt_rdy,
                    "R10 idle after response", resp_code, C_IDLE);
            if (prev_resp_done) pd_seen = 1;
            tick;
        end
        snoop_valid = 1'b0; data_busy = 1'b0; prev_resp_done = 1'b0;
        chk(nresp == 1, "R10 one response per transaction", nresp, 1);
        chk(saw_trdy == (v.wr || v.hit), (v.wr || v.hit) ? "R4 strobe needed" : "R3 no strobe",
            saw_trdy, v.wr || v.hit);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nr, first_code, second_code;
        bit any;
        // R1 reset state
        tick; tick;
        @(negedge clk);
        chk(!tgt_rdy && !resp_valid && !wb_data_drive && resp_code == C_IDLE,
            "R1 reset outputs", resp_code, C_IDLE);
        tick;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tgt_rdy && !resp_valid && resp_code == C_IDLE, "R1 first cycle out", resp_code, C_IDLE);
        tick;

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R12 stray snoop is dropped
        snoop_valid = 1'b1; snoop_hit_dirty = 1'b1; tick;
        snoop_valid = 1'b0;
        issue(1'b0);
        any = 0;
        prev_resp_done = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (resp_valid || tgt_rdy) any = 1;
            tick;
        end
        chk(!any, "R12 stray snoop ignored", any, 0);
        snoop_valid = 1'b1; snoop_hit_dirty = 1'b0; tick;
        snoop_valid = 1'b0;
        @(negedge clk); tick;
        @(negedge clk);
        chk(resp_valid && resp_code == C_NORM && !tgt_rdy, "R12 later snoop applies",
            resp_code, C_NORM);
        tick; tick;

        // R11 two outstanding requests answered in order
        req_valid = 1'b1; req_is_write = 1'b0; tick;
        tick;
        req_valid = 1'b0; tick;
        snoop_valid = 1'b1; snoop_hit_dirty = 1'b0; tick;
        snoop_hit_dirty = 1'b1; tick;
        snoop_valid = 1'b0;
        nr = 0; first_code = 0; second_code = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (resp_valid) begin
                if (nr == 0) first_code = resp_code; else second_code = resp_code;
                nr++;
            end
            tick;
        end
        chk(nr == 2, "R11 two responses", nr, 2);
        chk(first_code == C_NORM, "R11 first in order", first_code, C_NORM);
        chk(second_code == C_IWB, "R11 second in order", second_code, C_IWB);

        // R1 reset in mid-handshake drops the pending write
        prev_resp_done = 1'b0;
        issue(1'b1);
        data_busy = 1'b1;
        snoop_valid = 1'b1; snoop_hit_dirty = 1'b0; tick;
        snoop_valid = 1'b0; tick; tick;
        @(negedge clk);
        chk(tgt_rdy, "R7 strobe up while busy", tgt_rdy, 1);
        tick;
        rst_n = 1'b0; tick;
        @(negedge clk);
        chk(!tgt_rdy && !resp_valid && resp_code == C_IDLE, "R1 mid reset", tgt_rdy, 0);
        tick;
        rst_n = 1'b1; data_busy = 1'b0;
        any = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (resp_valid || tgt_rdy) any = 1;
            tick;
        end
        chk(!any, "R1 pending cleared", any, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule